// File: doc/BRIEF.md
# Signed Reciprocal Lookup Table

The block approximates a function of a signed fixed-point operand, by default a saturating reciprocal, by reading a constant table. It builds a table index from the operand with an arithmetic right shift and a mask to the index width. That index addresses a read-only table whose entries are computed at elaboration and held fixed. The block returns the entry, cut down to the result width and read as a signed number, two clock cycles after the operand is presented.

A valid flag travels beside the data through the same two register stages, so downstream logic can tell real results apart. The table read is always enabled, so the result follows the operand stream every cycle whether or not the flag is set. Reset clears only what the block drives out: the result and its flag. The table has no write path, so reset cannot change its contents.

Top module: `recip_lut_unit`

## Requirements
- R1: The table index is the operand (IN_W bits, two's complement) shifted right arithmetically by SHIFT bits and then masked to its low log2(DEPTH) bits, which is floor(operand / 2^SHIFT) modulo DEPTH. When SHIFT is 0 only the mask is applied.
- R2: Entry k is built at elaboration. Let s be k read as a log2(DEPTH)-bit two's complement number. The entry is NUM / s, rounded toward zero, when s is nonzero. When s is zero the entry is the saturation value 2^(TBL_W-1)-1. Each entry is stored in TBL_W bits.
- R3: `result` is the stored entry masked to its low OUT_W bits, i.e. ANDed with 2^OUT_W - 1, and read as a signed OUT_W-bit number. Upper bits are dropped with no saturation.
- R4: `result` shows the entry for the operand sampled two rising edges earlier: one edge for the registered table read and one for the output register.
- R5: `result_vld` equals `operand_vld` as it was sampled two rising edges earlier.
- R6: The table read and the output register load on every cycle. `result` follows the operand stream even while `operand_vld` is low.
- R7: After any rising edge at which `rst` is high, `result` is 0 and `result_vld` is 0.
- R8: Reset leaves the table contents unchanged. An operand read after a reset returns the same result as before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers load on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output stage and valid pipeline |
| operand | input | IN_W | Signed operand used to form the table index |
| operand_vld | input | 1 | Marks the operand as meaningful |
| result | output | OUT_W | Signed, registered table entry |
| result_vld | output | 1 | Valid flag aligned with `result` |

## Verification
The bench builds two instances side by side. The first uses a 4-bit shift, 256 entries, 20-bit entries and a 12-bit result. In that instance the sign-extension of the shift and the wrap of large entries into the 12-bit result are both reached. The second uses a shift of zero, 64 entries and a 10-bit result. There the mask-only index path is exercised, and the most negative index value and the saturated zero entry are reached often.

// File: rtl/recip_lut_pkg.sv
package recip_lut_pkg;

  // Entry for table index k. The index is read as a two's complement value of
  // log2(depth) bits. Zero maps to the saturation value; otherwise num / idx.
  function automatic int recip_entry(input int k, input int depth,
                                     input int num, input int sat);
    int idx;
    idx = (k >= depth / 2) ? (k - depth) : k;
    if (idx == 0) return sat;
    return num / idx;
  endfunction

endpackage

// File: rtl/recip_addr_gen.sv
module recip_addr_gen #(
  parameter int IN_W   = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 8
) (
  input  logic [IN_W-1:0]   operand,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [IN_W-1:0] ADDR_MASK = IN_W'((1 << ADDR_W) - 1);

  logic signed [IN_W-1:0] shifted;

  generate
    if (SHIFT > 0) begin : g_shift
      assign shifted = $signed(operand) >>> SHIFT;
    end else begin : g_noshift
      assign shifted = $signed(operand);
    end
  endgenerate

  assign rd_addr = ADDR_W'(shifted & ADDR_MASK);
endmodule

// File: rtl/recip_rom.sv
module recip_rom #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 256,
  parameter int TBL_W  = 20,
  parameter int NUM    = 16384
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TBL_W-1:0]  rom_q
);
  import recip_lut_pkg::*;

  localparam int SAT = (1 << (TBL_W - 1)) - 1;

  logic [TBL_W-1:0] tbl [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign tbl[i] = TBL_W'(recip_entry(i, DEPTH, NUM, SAT));
    end
  endgenerate

  // Read is always enabled; the read register has no reset.
  always_ff @(posedge clk) begin
    rom_q <= tbl[rd_addr];
  end
endmodule

// File: rtl/recip_out_stage.sv
module recip_out_stage #(
  parameter int TBL_W = 20,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TBL_W-1:0] rom_q,
  input  logic             vld_s1,
  output logic [OUT_W-1:0] result,
  output logic             result_vld
);
  localparam logic [TBL_W-1:0] OUT_MASK = TBL_W'((1 << OUT_W) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      result_vld <= 1'b0;
    end else begin
      result     <= OUT_W'(rom_q & OUT_MASK);
      result_vld <= vld_s1;
    end
  end

  // R7
  reset_zero_chk: assert property (@(posedge clk) rst |=> result == '0);
  // R7
  reset_novld_chk: assert property (@(posedge clk) rst |=> !result_vld);
endmodule

// File: rtl/recip_lut_unit.sv
module recip_lut_unit #(
  parameter int IN_W  = 16,
  parameter int SHIFT = 4,
  parameter int DEPTH = 256,
  parameter int TBL_W = 20,
  parameter int OUT_W = 12,
  parameter int NUM   = 16384
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  operand,
  input  logic             operand_vld,
  output logic [OUT_W-1:0] result,
  output logic             result_vld
);
  import recip_lut_pkg::*;

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int SAT    = (1 << (TBL_W - 1)) - 1;

  logic [ADDR_W-1:0] rd_addr;
  logic [TBL_W-1:0]  rom_q;
  logic              vld_s1;
  logic [1:0]        warm;

  recip_addr_gen #(.IN_W(IN_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_addr (
    .operand (operand),
    .rd_addr (rd_addr)
  );

  recip_rom #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .TBL_W(TBL_W), .NUM(NUM)) u_rom (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rom_q   (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_s1 <= 1'b0;
    else     vld_s1 <= operand_vld;
  end

  recip_out_stage #(.TBL_W(TBL_W), .OUT_W(OUT_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .rom_q      (rom_q),
    .vld_s1     (vld_s1),
    .result     (result),
    .result_vld (result_vld)
  );

  // Counts non-reset edges (saturating) so checks never look before reset.
  always_ff @(posedge clk) begin
    if (rst)               warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R5
  vld_align_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (result_vld == $past(operand_vld, 2)));

  // R4
  data_path_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |->
      (result == OUT_W'(recip_entry(int'($past(rd_addr, 2)), DEPTH, NUM, SAT))));
endmodule

// File: tb/test_recip_lut_unit.sv
module test_recip_lut_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] op;
  logic        op_vld;
  logic [11:0] res_a;
  logic        vld_a;
  logic [9:0]  res_b;
  logic        vld_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  recip_lut_unit #(.IN_W(16), .SHIFT(4), .DEPTH(256), .TBL_W(20), .OUT_W(12),
                   .NUM(16384)) i_recip_lut_unit (
    .clk(clk), .rst(rst), .operand(op), .operand_vld(op_vld),
    .result(res_a), .result_vld(vld_a));

  recip_lut_unit #(.IN_W(16), .SHIFT(0), .DEPTH(64), .TBL_W(16), .OUT_W(10),
                   .NUM(4096)) i_recip_lut_unit_s0 (
    .clk(clk), .rst(rst), .operand(op), .operand_vld(op_vld),
    .result(res_b), .result_vld(vld_b));

  // R1: floor division by 2^sh, then wrap into [0, depth)
  function automatic int b_index(int op16, int sh, int depth);
    int v, d;
    v = (op16 >= 32768) ? op16 - 65536 : op16;
    d = 1 << sh;
    v = (v >= 0) ? v / d : -((-v + d - 1) / d);
    return ((v % depth) + depth) % depth;
  endfunction

  // R2: reciprocal of the signed index, saturated at zero
  function automatic int b_entry(int a, int depth, int tw, int num);
    int s;
    s = (a < depth / 2) ? a : a - depth;
    if (s == 0) return (1 << (tw - 1)) - 1;
    return num / s;
  endfunction

  // R3: keep the low ow bits, read as signed
  function automatic int b_trunc(int raw, int ow);
    int m, r;
    m = 1 << ow;
    r = ((raw % m) + m) % m;
    return (r >= m / 2) ? r - m : r;
  endfunction

  function automatic int b_expect(int k, int op16);
    if (k == 0) return b_trunc(b_entry(b_index(op16, 4, 256), 256, 20, 16384), 12);
    return b_trunc(b_entry(b_index(op16, 0, 64), 64, 16, 4096), 10);
  endfunction

  // Behavioural two-stage timing model built on the expected values
  int m_s1 [2];
  int m_out [2];
  bit m_s1v, m_outv, m_s1k = 1'b0, m_outk = 1'b0, m_outrst = 1'b0;

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      m_s1[k]  <= b_expect(k, int'(op));
      m_out[k] <= rst ? 0 : m_s1[k];
    end
    m_s1v    <= rst ? 1'b0 : op_vld;
    m_outv   <= rst ? 1'b0 : m_s1v;
    m_s1k    <= 1'b1;
    m_outk   <= rst ? 1'b1 : m_s1k;
    m_outrst <= rst;
  end

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic cycle(logic [15:0] o, logic v, logic r, string tag);
    string dt, vt;
    @(negedge clk);
    if (m_outk) begin
      dt = m_outrst ? "R7" : tag;
      vt = m_outrst ? "R7" : "R5";
      chk(dt, "inst_a result", int'($signed(res_a)), m_out[0]);
      chk(dt, "inst_b result", int'($signed(res_b)), m_out[1]);
      chk(vt, "inst_a valid", int'(vld_a), int'(m_outv));
      chk(vt, "inst_b valid", int'(vld_b), int'(m_outv));
    end
    op = o;
    op_vld = v;
    rst = r;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    int keep;
    void'($urandom(32'd1357));
    rst = 1'b1;
    op = '0;
    op_vld = 1'b0;
    for (int i = 0; i < 3; i++) cycle(16'h0000, 1'b1, 1'b1, "R7");
    // R7: outputs cleared while reset held, even with valid driven high
    cycle(16'h0000, 1'b1, 1'b0, "R7");
    // R2: index zero gives the saturated entry
    cycle(16'h0000, 1'b1, 1'b0, "R2");
    // R1: -1 keeps sign through the shift, index wraps to the top entry
    cycle(16'hFFFF, 1'b1, 1'b0, "R1");
    cycle(16'h7FFF, 1'b0, 1'b0, "R1");
    cycle(16'h8000, 1'b1, 1'b0, "R1");
    // R3: index 1 entry wraps when cut to the result width
    cycle(16'h0010, 1'b1, 1'b0, "R3");
    cycle(16'h0001, 1'b1, 1'b0, "R3");
    // R2: most negative index of each table
    cycle(16'h0800, 1'b1, 1'b0, "R2");
    cycle(16'h0020, 1'b0, 1'b0, "R2");
    // R6: valid low, data still flows
    for (int i = 0; i < 4; i++) cycle(16'(i * 16'h0130), 1'b0, 1'b0, "R6");
    // R4: random stream with random valid, occasional resets
    for (int i = 0; i < 3000; i++) begin
      if (i % 700 == 350) begin
        cycle(16'($urandom), 1'b1, 1'b1, "R7");
        cycle(16'($urandom), 1'b1, 1'b1, "R7");
      end else begin
        cycle(16'($urandom), 1'($urandom % 2), 1'b0, "R4");
      end
    end
    // R8: same operand before and after a reset returns the same result
    for (int i = 0; i < 4; i++) cycle(16'h1234, 1'b1, 1'b0, "R8");
    keep = int'($signed(res_a));
    for (int i = 0; i < 3; i++) cycle(16'h1234, 1'b1, 1'b1, "R7");
    for (int i = 0; i < 4; i++) cycle(16'h1234, 1'b1, 1'b0, "R8");
    chk("R8", "inst_a result after reset", int'($signed(res_a)), keep);
    chk("R8", "inst_a result vs table", keep, b_expect(0, 16'h1234));
    for (int i = 0; i < 3; i++) cycle(16'h0000, 1'b0, 1'b0, "R4");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete got 0 expected 1");
      summary();
      $finish;
    end
  end
endmodule